// File: doc/BRIEF.md
# Tournament Predictor Chooser

This block sits beside two component direction predictors in a fetch pipeline and decides, branch by branch, which of the two to trust. It holds a table of 2-bit chooser states addressed by bits of the fetch PC. At fetch, the table entry picked by the PC selects either component A or component B, and the block returns the chosen direction, the selected component and the table index. The pipeline carries that index with the branch.

When the branch resolves, the pipeline returns the saved index with one correctness bit per component. The entry moves only when exactly one component was right. It steps toward the winner and saturates at both ends. Agreement in correctness, whether both were right or both were wrong, leaves the entry unchanged. The two components are outside this block; their predictions and correctness bits are plain inputs.

Top module: `tournament_chooser`

## Requirements
- R1: After synchronous reset every table entry holds 2'b01 (weak A). Every lookup then selects component A, so `pred_use_b`=0 and `pred_taken` equals `lk_pred_a`.
- R2: The states are 00 (strong A), 01 (weak A), 10 (weak B) and 11 (strong B). `pred_use_b` is the upper bit of the looked-up entry, and `pred_taken` equals `lk_pred_b` when that bit is 1 and `lk_pred_a` otherwise.
- R3: A resolve with `rs_a_ok` equal to `rs_b_ok` leaves the addressed entry unchanged.
- R4: A resolve with only `rs_a_ok` set lowers the entry by one step, and an entry already at 00 stays at 00.
- R5: A resolve with only `rs_b_ok` set raises the entry by one step, and an entry already at 11 stays at 11.
- R6: From a strong state, two single-winner resolves against the favoured component are needed before the selection flips. After one such resolve the selection is unchanged.
- R7: The lookup index `lk_idx` equals PC bits [10:2], and all other PC bits have no effect.
- R8: When a lookup and a resolve address the same entry in the same cycle, the lookup sees the value before the update. The updated value is seen from the next cycle on.
- R9: When `rs_valid` is 0, the correctness inputs change no entry.
- R10: A resolve changes only the entry at `rs_idx`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | 32 | Fetch PC for the lookup |
| lk_pred_a | input | 1 | Direction from component A |
| lk_pred_b | input | 1 | Direction from component B |
| pred_taken | output | 1 | Final chosen direction |
| pred_use_b | output | 1 | 1 when component B was chosen |
| lk_idx | output | 9 | Chooser index for the pipeline to save |
| rs_valid | input | 1 | Resolve update strobe |
| rs_idx | input | 9 | Saved chooser index of the resolving branch |
| rs_a_ok | input | 1 | Component A was correct |
| rs_b_ok | input | 1 | Component B was correct |

## Verification
The in-RTL assertions check four things on every cycle. A resolve where both components were equally correct leaves the state unchanged. A single winner moves the state by at most one step, in that winner's direction. An idle resolve port leaves a steadily addressed entry stable. Reset values, index extraction, the read-before-write ordering on a same-entry collision, the two-step hysteresis from a strong state, and isolation between entries only show up across the bench's scenarios. Those scenarios compare the block against a behavioural table model after every clock.

// File: rtl/chooser_pkg.sv
package chooser_pkg;

    typedef enum logic [1:0] {
        CH_A_STRONG = 2'b00,
        CH_A_WEAK   = 2'b01,
        CH_B_WEAK   = 2'b10,
        CH_B_STRONG = 2'b11
    } ch_state_e;

    localparam ch_state_e CH_RESET_STATE = CH_A_WEAK;

    typedef struct packed {
        logic a_ok;
        logic b_ok;
    } ch_verdict_t;

    function automatic logic ch_selects_b(input ch_state_e s);
        return s[1];
    endfunction

    function automatic ch_state_e ch_step(input ch_state_e s, input ch_verdict_t v);
        ch_state_e r;
        r = s;
        if (v.a_ok && !v.b_ok) begin
            if (s != CH_A_STRONG) r = ch_state_e'(s - 2'd1);
        end else if (v.b_ok && !v.a_ok) begin
            if (s != CH_B_STRONG) r = ch_state_e'(s + 2'd1);
        end
        return r;
    endfunction

endpackage

// File: rtl/chooser_table.sv
module chooser_table
    import chooser_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output ch_state_e        rd_state,
    input  logic [IDX_W-1:0] mod_idx,
    output ch_state_e        mod_state,
    input  logic             wr_en,
    input  ch_state_e        wr_state
);
    localparam int DEPTH = 1 << IDX_W;

    ch_state_e entries [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) entries[i] <= CH_RESET_STATE;
        end else if (wr_en) begin
            entries[mod_idx] <= wr_state;
        end
    end

    assign rd_state  = entries[rd_idx];
    assign mod_state = entries[mod_idx];

    // R9: with no write and a steady read address, the looked-up state holds
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && $stable(rd_idx)) |=> (!$past(wr_en) && $stable(rd_idx)) -> $stable(rd_state));

endmodule

// File: rtl/chooser_update.sv
module chooser_update
    import chooser_pkg::*;
(
    input  logic        valid,
    input  ch_state_e   cur_state,
    input  ch_verdict_t verdict,
    output logic        wr_en,
    output ch_state_e   nxt_state
);
    assign nxt_state = ch_step(cur_state, verdict);
    assign wr_en     = valid && (nxt_state != cur_state);
endmodule

// File: rtl/tournament_chooser.sv
module tournament_chooser
    import chooser_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int IDX_W  = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PC_W-1:0]  lk_pc,
    input  logic             lk_pred_a,
    input  logic             lk_pred_b,
    output logic             pred_taken,
    output logic             pred_use_b,
    output logic [IDX_W-1:0] lk_idx,
    input  logic             rs_valid,
    input  logic [IDX_W-1:0] rs_idx,
    input  logic             rs_a_ok,
    input  logic             rs_b_ok
);
    ch_state_e   look_state;
    ch_state_e   res_state;
    ch_state_e   new_state;
    ch_verdict_t verdict;
    logic        table_we;

    assign lk_idx  = lk_pc[PC_LSB +: IDX_W];
    assign verdict = '{a_ok: rs_a_ok, b_ok: rs_b_ok};

    chooser_table #(.IDX_W(IDX_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (lk_idx),
        .rd_state  (look_state),
        .mod_idx   (rs_idx),
        .mod_state (res_state),
        .wr_en     (table_we),
        .wr_state  (new_state)
    );

    chooser_update u_update (
        .valid     (rs_valid),
        .cur_state (res_state),
        .verdict   (verdict),
        .wr_en     (table_we),
        .nxt_state (new_state)
    );

    assign pred_use_b = ch_selects_b(look_state);
    assign pred_taken = pred_use_b ? lk_pred_b : lk_pred_a;

    logic [1:0] cur_v, nxt_v;
    assign cur_v = res_state;
    assign nxt_v = new_state;

    // R3: equal correctness never writes the table
    assert_tie_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && (rs_a_ok == rs_b_ok)) |-> !table_we);

    // R4: an A-only win moves at most one step down
    assert_a_win_step_R4: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && rs_a_ok && !rs_b_ok) |-> (nxt_v <= cur_v) && ((cur_v - nxt_v) <= 2'd1));

    // R5: a B-only win moves at most one step up
    assert_b_win_step_R5: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && rs_b_ok && !rs_a_ok) |-> (nxt_v >= cur_v) && ((nxt_v - cur_v) <= 2'd1));

    // R10: the entry at the resolved index holds the written value next cycle
    assert_write_lands_R10: assert property (@(posedge clk) disable iff (rst)
        (table_we && (rs_idx == lk_idx)) |=> ($past(rs_idx) == lk_idx) -> (look_state == $past(new_state)));

endmodule

// File: tb/test_tournament_chooser.sv
module test_tournament_chooser;
    localparam int IDX_W = 9;
    localparam int DEPTH = 1 << IDX_W;

    logic             clk = 0;
    logic             rst = 1;
    logic [31:0]      lk_pc = '0;
    logic             lk_pred_a = 0, lk_pred_b = 0;
    logic             pred_taken, pred_use_b;
    logic [IDX_W-1:0] lk_idx;
    logic             rs_valid = 0;
    logic [IDX_W-1:0] rs_idx = '0;
    logic             rs_a_ok = 0, rs_b_ok = 0;

    int checks = 0;
    int errors = 0;
    int model [DEPTH];

    always #2 clk = ~clk;

    tournament_chooser i_tournament_chooser (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_pred_a(lk_pred_a), .lk_pred_b(lk_pred_b),
        .pred_taken(pred_taken), .pred_use_b(pred_use_b), .lk_idx(lk_idx),
        .rs_valid(rs_valid), .rs_idx(rs_idx), .rs_a_ok(rs_a_ok), .rs_b_ok(rs_b_ok)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check combinational lookup, then model the update
    task automatic step(input logic [31:0] pc, input logic pa, input logic pb,
                        input logic rv, input int ridx, input logic aok, input logic bok,
                        input string tag);
        int mi, sel, exp_pred;
        @(negedge clk);
        lk_pc = pc; lk_pred_a = pa; lk_pred_b = pb;
        rs_valid = rv; rs_idx = ridx[IDX_W-1:0]; rs_a_ok = aok; rs_b_ok = bok;
        #1;
        mi = (pc >> 2) % DEPTH;
        sel = (model[mi] >= 2) ? 1 : 0;
        exp_pred = sel ? pb : pa;
        check(tag, "lk_idx", lk_idx, mi);
        check(tag, "pred_use_b", pred_use_b, sel);
        check(tag, "pred_taken", pred_taken, exp_pred);
        if (rv) begin
            if (aok && !bok && model[ridx] > 0) model[ridx]--;
            if (bok && !aok && model[ridx] < 3) model[ridx]++;
        end
    endtask

    function automatic logic [31:0] pc_of(input int idx, input int hi);
        return (32'(hi) << 11) | (32'(idx) << 2) | 32'(hi & 3);
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: reset state selects A everywhere
        for (int i = 0; i < DEPTH; i += 37) step(pc_of(i, i), 1'b1, 1'b0, 0, 0, 0, 0, "R1");
        check("R1", "use_b after reset", pred_use_b, 0);

        // R7: upper and lower PC bits do not alter the index
        step(32'hFFFF_F803, 1'b0, 1'b1, 0, 0, 0, 0, "R7");
        step(32'h0000_0FFC, 1'b1, 1'b0, 0, 0, 0, 0, "R7");
        check("R7", "index of 0xFFC", lk_idx, 511);

        // R5: B-only wins raise 01 -> 10 -> 11 and saturate
        step(pc_of(5, 1), 1, 0, 1, 5, 0, 1, "R5");
        step(pc_of(5, 2), 1, 0, 1, 5, 0, 1, "R5");   // looks up 10: selects B
        check("R2", "weak B selects B", pred_use_b, 1);
        step(pc_of(5, 3), 1, 0, 1, 5, 0, 1, "R5");
        step(pc_of(5, 4), 0, 1, 0, 0, 0, 0, "R5");
        check("R5", "saturated B pred", pred_taken, 1);

        // R6: one A-only win from strong B keeps B, the second flips to A
        step(pc_of(5, 5), 1, 0, 1, 5, 1, 0, "R6");
        step(pc_of(5, 6), 1, 0, 1, 5, 1, 0, "R6");
        check("R6", "still B after one loss", pred_use_b, 1);
        step(pc_of(5, 7), 1, 0, 0, 0, 0, 0, "R6");
        check("R6", "A after two losses", pred_use_b, 0);

        // R4: A-only wins reach 00 and saturate
        step(pc_of(5, 8), 1, 0, 1, 5, 1, 0, "R4");
        step(pc_of(5, 9), 1, 0, 1, 5, 1, 0, "R4");
        step(pc_of(5, 9), 0, 1, 1, 5, 0, 1, "R4");   // 00 -> 01
        step(pc_of(5, 9), 0, 1, 0, 0, 0, 0, "R4");
        check("R4", "one B win from 00 stays A", pred_use_b, 0);

        // R3: ties leave the entry alone
        for (int k = 0; k < 4; k++) step(pc_of(5, k), 0, 1, 1, 5, k[0], k[0], "R3");
        step(pc_of(5, 0), 0, 1, 0, 0, 0, 0, "R3");
        check("R3", "tie keeps A", pred_use_b, 0);

        // R9: correctness bits with valid low change nothing
        for (int k = 0; k < 4; k++) step(pc_of(5, 1), 0, 1, 0, 5, 0, 1, "R9");
        check("R9", "idle keeps A", pred_use_b, 0);

        // R8: same-entry collision reads old value
        step(pc_of(5, 2), 0, 1, 1, 5, 0, 1, "R8");
        check("R8", "collision sees old A", pred_use_b, 0);
        step(pc_of(5, 2), 0, 1, 0, 0, 0, 0, "R8");
        check("R8", "next cycle sees B", pred_use_b, 1);

        // R10: neighbours untouched by index 5 activity
        step(pc_of(4, 0), 1, 0, 0, 0, 0, 0, "R10");
        step(pc_of(6, 0), 1, 0, 0, 0, 0, 0, "R10");
        check("R10", "neighbour selects A", pred_use_b, 0);

        // R2: mixed pattern across several entries
        for (int k = 0; k < 64; k++)
            step(pc_of((k * 13) % DEPTH, k), k[1], k[2], 1, (k * 7) % DEPTH, k[0], k[3], "R2");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule